// File: doc/BRIEF.md
# Shared Command/Data Bus Sequencer

This block is the host-side front end of a 64-bit associative memory whose only link to the host is one 32-bit bus. The same bus carries instruction words and data words. On each cycle where the enable strobe is high, two active-low controls say which of four cycle kinds is taking place. The block decodes the kind at the clock edge and updates its internal state there. On read cycles it drives the answer onto the bus combinationally during that cycle.

An instruction word travels in the upper half of a command write. It either picks the target of later data cycles (the comparand, one of two mask registers, or the memory port), or it opens a two-cycle access to one of a small bank of 16-bit control registers. When the access is a read, it must be collected on the next enabled cycle, and that cycle must be a command read. Any other cycle in that slot cancels the read. When the access is a write, the next command write carries the new register value in its lower half.

Data moves as 64-bit words split into two bus halves, low half first. A half pointer keeps track of which half comes next.

Top module: `cam_bus_sequencer`

## Requirements
- R1: With `cyc_en` high, the cycle kind is decoded as follows: `w_n`=0 and `cm_n`=0 is a command write, `w_n`=1 and `cm_n`=0 is a command read, `w_n`=0 and `cm_n`=1 is a data write, and `w_n`=1 and `cm_n`=1 is a data read. `bus_oe` is 1 exactly during enabled read cycles. `bus_out` is 0 whenever `bus_oe` is 0.
- R2: A command read with no register read armed returns `status_in` on all 32 bits.
- R3: A command write with bit 31 = 1 (register access) and bit 30 = 0 (f flag) arms a read of register `bus_in[18:16]`. If the next enabled cycle is a command read, it returns that register in bits 15:0 and `status_in[31:16]` in bits 31:16. The armed read is then cleared, so a further command read returns status again.
- R4: When the armed read targets register 7 (page register), bits 31:16 of the returned word are 0.
- R5: An armed read is cancelled when the next enabled cycle is a command write, a data write or a data read. A later command read then returns `status_in`.
- R6: A register-access command write with f = 1 makes the next enabled command write store its `bus_in[15:0]` into register `bus_in[18:16]` of the instruction. That following word is not decoded as an instruction. If the next enabled cycle is not a command write, the pending write is dropped.
- R7: A command write with bit 31 = 0 sets the data target from `bus_in[17:16]`: 0 is the comparand, 1 is mask 0, 2 is mask 1, and 3 is memory. If f = 1, `mem_addr` is also loaded from `bus_in[15:0]`. If f = 0, `mem_addr` keeps its value.
- R8: Two data writes to the comparand or to a mask fill bits 31:0 and then bits 63:32 of that register.
- R9: After two data writes to the memory target, `mem_we` is high for exactly one cycle. During that cycle `mem_wdata` holds {second half, first half}.
- R10: Data reads return the low half and then the high half of the current target. For the memory target, the value comes from `mem_rdata`.
- R11: Every enabled command cycle returns the half pointer to the low half.
- R12: After reset, no register access is armed or pending, and the half pointer is low. The comparand, both masks and `mem_addr` are 0, `mem_we` is 0, and all control registers are 0.
- R13: A cycle with `cyc_en` low changes no state. An armed read survives it, and so does a pending write or a half pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Cycle enable strobe |
| w_n | input | 1 | Active-low write control |
| cm_n | input | 1 | Active-low command control |
| bus_in | input | 32 | Bus value from the host |
| bus_out | output | 32 | Bus value to the host on read cycles |
| bus_oe | output | 1 | Bus drive enable |
| status_in | input | 32 | Live status word |
| comparand | output | 64 | Comparand register |
| mask0 | output | 64 | Mask register 0 |
| mask1 | output | 64 | Mask register 1 |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | One-cycle memory write pulse |
| mem_wdata | output | 64 | Memory write word |
| mem_rdata | input | 64 | Memory read word at `mem_addr` |

## Verification
The hardest case to reach from the ports is how an armed read or a pending write interacts with the cycle right after it. That cycle might cancel the access. It might be an idle cycle that must leave the access alive. It might be a command write whose upper half would arm a new access if it were decoded. Directed sequences place each cycle kind, and idle strobes, in that slot. Seeded random traffic then biases toward register-access instructions, so that arm, cancel and pending-write chains happen back to back and overlap with half-finished data transfers. A bench model predicts each returned word.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    CYC_CMD_WR = 2'd0,
    CYC_CMD_RD = 2'd1,
    CYC_DAT_WR = 2'd2,
    CYC_DAT_RD = 2'd3
  } cyc_kind_t;

  // w_n selects read (1) / write (0), cm_n selects data (1) / command (0)
  function automatic cyc_kind_t decode_kind(input logic w_n, input logic cm_n);
    cyc_kind_t k;
    case ({cm_n, w_n})
      2'b00:   k = CYC_CMD_WR;
      2'b01:   k = CYC_CMD_RD;
      2'b10:   k = CYC_DAT_WR;
      default: k = CYC_DAT_RD;
    endcase
    return k;
  endfunction

  // register readback word: upper half is live status or zero for the page register
  function automatic logic [31:0] regread_word(input logic [15:0] status_hi,
                                               input logic [15:0] value,
                                               input logic        is_page);
    logic [15:0] hi;
    hi = is_page ? 16'h0000 : status_hi;
    return {hi, value};
  endfunction

  // pick one 32-bit half of a 64-bit word
  function automatic logic [31:0] pick_half(input logic [63:0] word, input logic upper);
    return upper ? word[63:32] : word[31:0];
  endfunction

  // merge a 32-bit half into a 64-bit word
  function automatic logic [63:0] merge_half(input logic [63:0] word,
                                             input logic [31:0] half,
                                             input logic        upper);
    logic [63:0] r;
    r = word;
    if (upper) r[63:32] = half;
    else       r[31:0]  = half;
    return r;
  endfunction

endpackage

// File: rtl/cbs_cycle_decode.sv
module cbs_cycle_decode
  import cbs_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             cyc_en,
  input  logic             w_n,
  input  logic             cm_n,
  input  logic [BUS_W-1:0] bus_in,
  output logic             is_cmd_wr,
  output logic             is_cmd_rd,
  output logic             is_dat_wr,
  output logic             is_dat_rd,
  output logic             instr_reg,
  output logic             instr_f,
  output logic [BUS_W/2-1:0] instr_word,
  output logic [BUS_W/2-1:0] low_word
);
  localparam int HALF_W = BUS_W / 2;

  cyc_kind_t kind;

  always_comb begin
    kind      = decode_kind(w_n, cm_n);
    is_cmd_wr = cyc_en && (kind == CYC_CMD_WR);
    is_cmd_rd = cyc_en && (kind == CYC_CMD_RD);
    is_dat_wr = cyc_en && (kind == CYC_DAT_WR);
    is_dat_rd = cyc_en && (kind == CYC_DAT_RD);
  end

  assign instr_word = bus_in[BUS_W-1:HALF_W];
  assign low_word   = bus_in[HALF_W-1:0];
  assign instr_reg  = bus_in[BUS_W-1];
  assign instr_f    = bus_in[BUS_W-2];

  always_comb begin
    assert ($countones({is_cmd_wr, is_cmd_rd, is_dat_wr, is_dat_rd}) <= 1)
      else $error("p_one_kind_r1: more than one cycle kind decoded");
  end

endmodule

// File: rtl/cbs_reg_bank.sv
module cbs_reg_bank #(
  parameter int NREG  = 8,
  parameter int REG_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [REG_W-1:0]        wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [REG_W-1:0]        rdata
);
  localparam int IDX_W = $clog2(NREG);

  logic [REG_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                regs[g] <= '0;
      else if (we && (waddr == IDX_W'(g)))       regs[g] <= wdata;
    end
  end

  assign rdata = regs[raddr];

endmodule

// File: rtl/cbs_data_path.sv
module cbs_data_path
  import cbs_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 16,
  parameter int TGT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_cycle,
  input  logic               dat_wr,
  input  logic               dat_rd,
  input  logic               tgt_load,
  input  logic [TGT_W-1:0]   tgt_val,
  input  logic               addr_load,
  input  logic [ADDR_W-1:0]  addr_val,
  input  logic [BUS_W-1:0]   wr_half,
  input  logic [2*BUS_W-1:0] mem_rdata,
  output logic [BUS_W-1:0]   rd_half,
  output logic [2*BUS_W-1:0] comparand,
  output logic [2*BUS_W-1:0] mask0,
  output logic [2*BUS_W-1:0] mask1,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic [2*BUS_W-1:0] mem_wdata
);
  localparam int DATA_W   = 2 * BUS_W;
  localparam int NMASK    = 2;
  localparam logic [TGT_W-1:0] TGT_MEM = TGT_W'(NMASK + 1);

  logic [TGT_W-1:0]  tgt_q;
  logic              half_q;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] mask_q [NMASK];
  logic [BUS_W-1:0]  stage_q;
  logic              mem_we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] addr_q;

  logic              to_mem;
  logic              hit_cmp;
  logic              mem_commit;
  logic [DATA_W-1:0] cur_word;

  assign to_mem     = (tgt_q == TGT_MEM);
  assign hit_cmp    = dat_wr && (tgt_q == '0);
  assign mem_commit = dat_wr && to_mem && half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      addr_q <= '0;
    end else begin
      if (tgt_load)  tgt_q  <= tgt_val;
      if (addr_load) addr_q <= addr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 half_q <= 1'b0;
    else if (cmd_cycle)         half_q <= 1'b0;
    else if (dat_wr || dat_rd)  half_q <= !half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_q <= '0;
    else if (hit_cmp) cmp_q <= merge_half(cmp_q, wr_half, half_q);
  end

  for (genvar m = 0; m < NMASK; m++) begin : g_mask
    logic hit_mask;
    assign hit_mask = dat_wr && (tgt_q == TGT_W'(m + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q[m] <= '0;
      else if (hit_mask) mask_q[m] <= merge_half(mask_q[m], wr_half, half_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      mem_we_q <= 1'b0;
      wdata_q  <= '0;
    end else begin
      mem_we_q <= mem_commit;
      if (dat_wr && to_mem && !half_q) stage_q <= wr_half;
      if (mem_commit)                  wdata_q <= {wr_half, stage_q};
    end
  end

  always_comb begin
    case (tgt_q)
      2'd0:    cur_word = cmp_q;
      2'd1:    cur_word = mask_q[0];
      2'd2:    cur_word = mask_q[1];
      default: cur_word = mem_rdata;
    endcase
    rd_half = pick_half(cur_word, half_q);
  end

  assign comparand = cmp_q;
  assign mask0     = mask_q[0];
  assign mask1     = mask_q[1];
  assign mem_addr  = addr_q;
  assign mem_we    = mem_we_q;
  assign mem_wdata = wdata_q;

  p_half_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cycle |=> !half_q);

  p_memwe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_memwe_low_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !half_q);

  p_data_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cycle && !dat_wr && !dat_rd && !tgt_load) |=> ($stable(cmp_q) && $stable(half_q)));

endmodule

// File: rtl/cam_bus_sequencer.sv
module cam_bus_sequencer
  import cbs_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int NREG     = 8,
  parameter int PAGE_IDX = 7,
  parameter int ADDR_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_en,
  input  logic               w_n,
  input  logic               cm_n,
  input  logic [BUS_W-1:0]   bus_in,
  output logic [BUS_W-1:0]   bus_out,
  output logic               bus_oe,
  input  logic [BUS_W-1:0]   status_in,
  output logic [2*BUS_W-1:0] comparand,
  output logic [2*BUS_W-1:0] mask0,
  output logic [2*BUS_W-1:0] mask1,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic [2*BUS_W-1:0] mem_wdata,
  input  logic [2*BUS_W-1:0] mem_rdata
);
  localparam int HALF_W = BUS_W / 2;
  localparam int IDX_W  = $clog2(NREG);
  localparam int TGT_W  = 2;

  logic              is_cmd_wr, is_cmd_rd, is_dat_wr, is_dat_rd;
  logic              instr_reg, instr_f;
  logic [HALF_W-1:0] instr_word, low_word;

  cbs_cycle_decode #(.BUS_W(BUS_W)) u_dec (
    .cyc_en    (cyc_en),
    .w_n       (w_n),
    .cm_n      (cm_n),
    .bus_in    (bus_in),
    .is_cmd_wr (is_cmd_wr),
    .is_cmd_rd (is_cmd_rd),
    .is_dat_wr (is_dat_wr),
    .is_dat_rd (is_dat_rd),
    .instr_reg (instr_reg),
    .instr_f   (instr_f),
    .instr_word(instr_word),
    .low_word  (low_word)
  );

  logic             arm_q, wpend_q;
  logic [IDX_W-1:0] sel_idx_q;

  logic             decode_instr;
  logic             arm_set, wpend_set, reg_we, rd_reg_hit;
  logic             tgt_load, addr_load;
  logic [HALF_W-1:0] reg_rdata;
  logic [BUS_W-1:0] dp_rd_half;

  assign decode_instr = is_cmd_wr && !wpend_q;
  assign arm_set      = decode_instr && instr_reg && !instr_f;
  assign wpend_set    = decode_instr && instr_reg && instr_f;
  assign reg_we       = is_cmd_wr && wpend_q;
  assign rd_reg_hit   = is_cmd_rd && arm_q;
  assign tgt_load     = decode_instr && !instr_reg;
  assign addr_load    = tgt_load && instr_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q     <= 1'b0;
      wpend_q   <= 1'b0;
      sel_idx_q <= '0;
    end else if (cyc_en) begin
      arm_q   <= arm_set;
      wpend_q <= wpend_set;
      if (arm_set || wpend_set) sel_idx_q <= instr_word[IDX_W-1:0];
    end
  end

  cbs_reg_bank #(.NREG(NREG), .REG_W(HALF_W)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .waddr(sel_idx_q),
    .wdata(low_word),
    .raddr(sel_idx_q),
    .rdata(reg_rdata)
  );

  cbs_data_path #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_cycle(is_cmd_wr || is_cmd_rd),
    .dat_wr   (is_dat_wr),
    .dat_rd   (is_dat_rd),
    .tgt_load (tgt_load),
    .tgt_val  (instr_word[TGT_W-1:0]),
    .addr_load(addr_load),
    .addr_val (ADDR_W'(low_word)),
    .wr_half  (bus_in),
    .mem_rdata(mem_rdata),
    .rd_half  (dp_rd_half),
    .comparand(comparand),
    .mask0    (mask0),
    .mask1    (mask1),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata)
  );

  always_comb begin
    bus_oe  = is_cmd_rd || is_dat_rd;
    bus_out = '0;
    if (rd_reg_hit)
      bus_out = regread_word(status_in[BUS_W-1:HALF_W], reg_rdata,
                             sel_idx_q == IDX_W'(PAGE_IDX));
    else if (is_cmd_rd)
      bus_out = status_in;
    else if (is_dat_rd)
      bus_out = dp_rd_half;
  end

  p_arm_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && arm_q && !arm_set) |=> !arm_q);

  p_page_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg_hit && (sel_idx_q == IDX_W'(PAGE_IDX))) |-> (bus_out[BUS_W-1:HALF_W] == '0));

  p_value_not_decoded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (!arm_set && !wpend_set && !tgt_load));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> ($stable(arm_q) && $stable(wpend_q) && $stable(sel_idx_q)));

  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));

endmodule

// File: tb/cam_bus_sequencer_bench.sv
module cam_bus_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_en, w_n, cm_n;
  logic [31:0] bus_in, bus_out, status_in;
  logic        bus_oe, mem_we;
  logic [63:0] comparand, mask0, mask1, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  cam_bus_sequencer u_cam_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .w_n(w_n), .cm_n(cm_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .status_in(status_in),
    .comparand(comparand), .mask0(mask0), .mask1(mask1), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  logic [15:0] m_reg [8];
  logic        m_arm, m_wp, m_half, m_we;
  logic [2:0]  m_idx;
  logic [1:0]  m_tgt;
  logic [15:0] m_addr;
  logic [31:0] m_stage;
  logic [63:0] m_cmp, m_m0, m_m1, m_wdata;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] tgt_word();
    case (m_tgt)
      2'd0: return m_cmp;
      2'd1: return m_m0;
      2'd2: return m_m1;
      default: return mem_rdata;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic w, input logic cm);
    logic [63:0] t;
    if (!cm && m_arm) return {(m_idx == 3'd7) ? 16'h0 : status_in[31:16], m_reg[m_idx]};
    if (!cm) return status_in;
    t = tgt_word();
    return m_half ? t[63:32] : t[31:0];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_arm = 0; m_wp = 0; m_half = 0; m_we = 0; m_idx = 0; m_tgt = 0;
    m_addr = 0; m_stage = 0; m_cmp = 0; m_m0 = 0; m_m1 = 0; m_wdata = 0;
  endtask

  task automatic model_step(input logic en, input logic w, input logic cm, input logic [31:0] d);
    m_we = 0;
    if (!en) return;
    if (!cm && !w) begin
      if (m_wp) begin
        m_reg[m_idx] = d[15:0];
        m_wp = 0; m_arm = 0;
      end else begin
        m_arm = 0; m_wp = 0;
        if (d[31]) begin
          m_idx = d[18:16];
          if (d[30]) m_wp = 1; else m_arm = 1;
        end else begin
          m_tgt = d[17:16];
          if (d[30]) m_addr = d[15:0];
        end
      end
      m_half = 0;
    end else if (!cm && w) begin
      m_arm = 0; m_wp = 0; m_half = 0;
    end else if (cm && !w) begin
      m_arm = 0; m_wp = 0;
      case (m_tgt)
        2'd0: if (m_half) m_cmp[63:32] = d; else m_cmp[31:0] = d;
        2'd1: if (m_half) m_m0[63:32]  = d; else m_m0[31:0]  = d;
        2'd2: if (m_half) m_m1[63:32]  = d; else m_m1[31:0]  = d;
        default: if (m_half) begin m_we = 1; m_wdata = {d, m_stage}; end
                 else m_stage = d;
      endcase
      m_half = !m_half;
    end else begin
      m_arm = 0; m_wp = 0; m_half = !m_half;
    end
  endtask

  task automatic cyc(input logic en, input logic w, input logic cm,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    cyc_en = en; w_n = w; cm_n = cm; bus_in = d;
    status_in = $urandom; mem_rdata = {$urandom, $urandom};
    #1;
    chk({tag, " R1 oe"}, 64'(bus_oe), 64'(en && w));
    if (en && w) chk({tag, " read"}, 64'(bus_out), 64'(exp_read(w, cm)));
    else         chk({tag, " R1 idle bus"}, 64'(bus_out), 64'h0);
    @(posedge clk);
    model_step(en, w, cm, d);
    #1;
    chk({tag, " cmp"}, comparand, m_cmp);
    chk({tag, " mask0"}, mask0, m_m0);
    chk({tag, " mask1"}, mask1, m_m1);
    chk({tag, " addr"}, 64'(mem_addr), 64'(m_addr));
    chk({tag, " R9 we"}, 64'(mem_we), 64'(m_we));
    if (m_we) chk({tag, " R9 wdata"}, mem_wdata, m_wdata);
  endtask

  task automatic cmdw(input logic [31:0] d, input string tag); cyc(1, 0, 0, d, tag); endtask
  task automatic cmdr(input string tag);                       cyc(1, 1, 0, $urandom, tag); endtask
  task automatic datw(input logic [31:0] d, input string tag); cyc(1, 0, 1, d, tag); endtask
  task automatic datr(input string tag);                       cyc(1, 1, 1, $urandom, tag); endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1485));
    cyc_en = 0; w_n = 1; cm_n = 1; bus_in = 0; status_in = 0; mem_rdata = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R12 cmp", comparand, 64'h0);
    chk("R12 mask0", mask0, 64'h0);
    chk("R12 mask1", mask1, 64'h0);
    chk("R12 addr", 64'(mem_addr), 64'h0);
    chk("R12 we", 64'(mem_we), 64'h0);
    rst_n = 1;
    // R12: first command read after reset returns status (nothing armed)
    cmdr("R12 R2");
    // R12: registers zero after reset
    cmdw(32'h8003_0000, "R12 arm"); cmdr("R12 reg zero");
    // R6: pending write, next word's upper half would arm if decoded
    cmdw(32'hC002_FFFF, "R6 open");
    cmdw(32'h8005_1234, "R6 value");
    cmdw(32'h8002_0000, "R3 arm"); cmdr("R3 collect"); cmdr("R3 one shot R2");
    // R4 page register
    cmdw(32'hC007_0000, "R4 open"); cmdw(32'h0000_BEEF, "R4 value");
    cmdw(32'h8007_0000, "R4 arm"); cmdr("R4 collect");
    // R5 cancellations by each other kind
    cmdw(32'h8002_0000, "R5 arm"); datr("R5 cancel dr"); cmdr("R5 after dr");
    cmdw(32'h8002_0000, "R5 arm"); datw(32'h1, "R5 cancel dw"); cmdr("R5 after dw");
    cmdw(32'h8002_0000, "R5 arm"); cmdw(32'h0000_0000, "R5 cancel cw"); cmdr("R5 after cw");
    // R6 pending write dropped by a non-command-write cycle
    cmdw(32'hC001_0000, "R6 open"); cmdr("R6 drop");
    cmdw(32'h0000_0055, "R6 decoded"); cmdw(32'h8001_0000, "R6 arm"); cmdr("R6 unchanged");
    // R7 target select and address
    cmdw(32'h4003_00A5, "R7 addr load");
    cmdw(32'h0000_1111, "R7 addr keep");
    // R8 comparand and mask 1
    datw(32'hAAAA_0001, "R8 cmp lo"); datw(32'hBBBB_0002, "R8 cmp hi");
    cmdw(32'h0002_0000, "R8 sel m1");
    datw(32'h1357_9BDF, "R8 m1 lo"); datw(32'h2468_ACE0, "R8 m1 hi");
    datr("R10 m1 lo"); datr("R10 m1 hi");
    // R9 memory
    cmdw(32'h4003_0042, "R9 sel mem");
    datw(32'hDEAD_BEEF, "R9 lo"); datw(32'hCAFE_F00D, "R9 hi");
    cyc(0, 1, 1, 0, "R9 after pulse");
    datr("R10 mem lo"); datr("R10 mem hi");
    // R11 half reset by command cycle
    cmdw(32'h0000_0000, "R11 sel cmp");
    datw(32'h0F0F_0F0F, "R11 half"); cmdr("R11 cmd"); datw(32'hF0F0_F0F0, "R11 low again");
    // R13 idle cycles preserve armed read and half pointer
    cmdw(32'h8002_0000, "R13 arm");
    cyc(0, 0, 0, 32'h8007_0000, "R13 idle cw");
    cyc(0, 0, 1, 32'h1234_5678, "R13 idle dw");
    cmdr("R13 collect");
    datw(32'h7777_7777, "R13 lo"); cyc(0, 1, 1, 0, "R13 idle"); datw(32'h8888_8888, "R13 hi");
    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int sel;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      d = $urandom;
      case (sel)
        0, 1: cmdw({1'b1, d[30], 11'h0, d[18:16], d[15:0]}, "R3 R6 rnd reg");
        2:    cmdw({1'b0, d[30], 12'h0, d[17:16], d[15:0]}, "R7 rnd sel");
        3, 4: cmdr("R2 R3 rnd cmdr");
        5:    datw(d, "R8 rnd dw");
        6:    datr("R10 rnd dr");
        7:    cyc(0, d[0], d[1], d, "R13 rnd idle");
        default: cmdw(d, "R1 rnd cw");
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule